// File: doc/BRIEF.md
# Dual-Link Frequency Select Register

This block holds the clock-rate selection for two serial links in a single configuration byte. Each link owns a 4-bit code. Software reads and writes the byte over a small register bus that has a byte address, a write strobe and combinational read data. A read-only revision byte sits at the adjacent address.

The two reset inputs behave differently. A cold reset loads each code from the board clock strapping. A warm reset leaves the stored codes untouched. The codes that drive the link clock generators are copied from the stored codes only while a reset is applied. As a result, a rate change that software writes stays pending until the next warm reset.

Each link has a sync-mode input. When it is high, that link's receiver clock select follows the latched transmitter code. When it is low, the receiver select sits at a fixed default. A status output marks any link whose stored code is not one of the three defined rates.

Top module: `link_freq_ctrl`

## Requirements
- R1: During cold reset (`cold_rst_n` low), each link's stored code loads 4'h0 when `strap_core_sel` is 1 and that link's 2-bit `strap_link_clk` slice equals 2'b01. Otherwise it loads 4'hF. When `alt_clk_mode` is 1, both codes load 4'hF whatever the strapping.
- R2: A read at address 8'h4D returns the stored byte, with link 1 in bits 7:4 and link 0 in bits 3:0. A write there stores any raw value, and the value can be read back one cycle later.
- R3: A write to any other address leaves both stored codes unchanged. A read of any address other than 8'h4C and 8'h4D returns 8'h00.
- R4: Warm reset (`warm_rst_n` low with `cold_rst_n` high) keeps both stored codes. Writes presented while warm reset is low are ignored.
- R5: `tx_freq_sel` has the same packing as the stored byte. It changes only on clock edges where a reset is applied. After warm reset is released it equals the stored byte. Writes made between resets do not change it.
- R6: For each link, the 4-bit slice of `rx_freq_sel` equals that link's `tx_freq_sel` slice while its `sync_mode` bit is 1. It equals 4'h0 while that bit is 0.
- R7: `code_reserved[i]` is 1 exactly when link i's stored code is not 4'h0 (200 MHz), 4'h2 (400 MHz) or 4'hF (vendor rate).
- R8: A read at address 8'h4C returns the revision byte 8'h20. Its minor field is in bits 4:0 and reads 0. Writes do not alter it.
- R9: After a cold reset, `tx_freq_sel` equals the cold-reset codes of R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| cold_rst_n | input | 1 | Synchronous active-low cold reset |
| warm_rst_n | input | 1 | Synchronous active-low warm reset |
| strap_core_sel | input | 1 | Core clock strap |
| strap_link_clk | input | 4 | Per-link 2-bit clock strap, link i in bits 2i+1:2i |
| alt_clk_mode | input | 1 | Alternate clocking option; forces the vendor code at cold reset |
| sync_mode | input | 2 | Per-link sync-mode enable |
| bus_addr | input | 8 | Register byte address |
| bus_wr_en | input | 1 | Write strobe |
| bus_wr_data | input | 8 | Write data |
| bus_rd_data | output | 8 | Read data for `bus_addr` |
| tx_freq_sel | output | 8 | Latched transmitter code per link |
| rx_freq_sel | output | 8 | Receiver code per link |
| code_reserved | output | 2 | Per-link reserved-code flag |

## Verification
Inputs change 2 ns after a rising edge. Outputs are compared at the following falling edge against a behavioural model that the bench advances on each rising edge. A write appears on `bus_rd_data` and `code_reserved` at the first falling edge after the edge that samples it. `bus_rd_data` and `rx_freq_sel` follow their address and sync inputs within the same cycle. `tx_freq_sel` picks up a pending write only at the first falling edge after the last edge sampled with reset low. Directed checks sample at those same falling edges, so every expectation falls in the cycle the register chain predicts.

// File: rtl/lfc_pkg.sv
package lfc_pkg;

   localparam int CODE_W = 4;

   typedef logic [CODE_W-1:0] freq_code_t;

   localparam freq_code_t CODE_200MHZ = 4'h0;
   localparam freq_code_t CODE_400MHZ = 4'h2;
   localparam freq_code_t CODE_VENDOR = 4'hF;

   function automatic logic code_is_reserved(input freq_code_t c);
      return !((c == CODE_200MHZ) || (c == CODE_400MHZ) || (c == CODE_VENDOR));
   endfunction

endpackage

// File: rtl/lfc_strap_decode.sv
module lfc_strap_decode
   import lfc_pkg::*;
#(
   parameter int          LCLK_W   = 2,
   parameter logic [1:0]  LCLK_200 = 2'b01
) (
   input  logic              core_sel,
   input  logic [LCLK_W-1:0] link_clk,
   input  logic              alt_clk,
   output freq_code_t        cold_code
);

   logic recognised;

   always_comb begin
      recognised = core_sel && (link_clk == LCLK_W'(LCLK_200));
      if (alt_clk)
         cold_code = CODE_VENDOR;
      else if (recognised)
         cold_code = CODE_200MHZ;
      else
         cold_code = CODE_VENDOR;
   end

endmodule

// File: rtl/lfc_link_field.sv
module lfc_link_field
   import lfc_pkg::*;
#(
   parameter freq_code_t RX_DEFAULT = 4'h0
) (
   input  logic       clk,
   input  logic       cold_rst_n,
   input  logic       warm_rst_n,
   input  freq_code_t cold_code,
   input  logic       wr_hit,
   input  freq_code_t wr_code,
   input  logic       sync_on,
   output freq_code_t field_q,
   output freq_code_t tx_sel,
   output freq_code_t rx_sel,
   output logic       reserved
);

   freq_code_t active_q;

   // stored code: strap at cold reset, frozen in warm reset, written otherwise
   always_ff @(posedge clk) begin
      if (!cold_rst_n)
         field_q <= cold_code;
      else if (warm_rst_n && wr_hit)
         field_q <= wr_code;
   end

   // active code: reloaded on every edge a reset is applied
   always_ff @(posedge clk) begin
      if (!cold_rst_n)
         active_q <= cold_code;
      else if (!warm_rst_n)
         active_q <= field_q;
   end

   always_comb begin
      tx_sel   = active_q;
      rx_sel   = sync_on ? active_q : RX_DEFAULT;
      reserved = code_is_reserved(field_q);
   end

endmodule

// File: rtl/lfc_rd_mux.sv
module lfc_rd_mux #(
   parameter int               ADDR_W    = 8,
   parameter int               DATA_W    = 8,
   parameter logic [ADDR_W-1:0] FREQ_ADDR = 8'h4D,
   parameter logic [ADDR_W-1:0] REV_ADDR  = 8'h4C,
   parameter logic [DATA_W-1:0] REV_BYTE  = 8'h20
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] freq_byte,
   output logic [DATA_W-1:0] rd_data
);

   always_comb begin
      if (addr == FREQ_ADDR)
         rd_data = freq_byte;
      else if (addr == REV_ADDR)
         rd_data = REV_BYTE;
      else
         rd_data = '0;
   end

endmodule

// File: rtl/link_freq_ctrl.sv
module link_freq_ctrl
   import lfc_pkg::*;
#(
   parameter int          NUM_LINKS  = 2,
   parameter int          ADDR_W     = 8,
   parameter logic [7:0]  FREQ_ADDR  = 8'h4D,
   parameter logic [7:0]  REV_ADDR   = 8'h4C,
   parameter logic [2:0]  REV_MAJOR  = 3'd1,
   parameter logic [4:0]  REV_MINOR  = 5'd0,
   parameter int          LCLK_W     = 2,
   parameter logic [1:0]  LCLK_200   = 2'b01,
   parameter logic [3:0]  RX_DEFAULT = 4'h0
) (
   input  logic                          clk,
   input  logic                          cold_rst_n,
   input  logic                          warm_rst_n,
   input  logic                          strap_core_sel,
   input  logic [NUM_LINKS*LCLK_W-1:0]   strap_link_clk,
   input  logic                          alt_clk_mode,
   input  logic [NUM_LINKS-1:0]          sync_mode,
   input  logic [ADDR_W-1:0]             bus_addr,
   input  logic                          bus_wr_en,
   input  logic [NUM_LINKS*CODE_W-1:0]   bus_wr_data,
   output logic [NUM_LINKS*CODE_W-1:0]   bus_rd_data,
   output logic [NUM_LINKS*CODE_W-1:0]   tx_freq_sel,
   output logic [NUM_LINKS*CODE_W-1:0]   rx_freq_sel,
   output logic [NUM_LINKS-1:0]          code_reserved
);

   localparam int DATA_W = NUM_LINKS * CODE_W;
   localparam logic [DATA_W-1:0] REV_BYTE = DATA_W'({REV_MAJOR, REV_MINOR});

   if (DATA_W != 8) begin : g_bad_width
      $error("link_freq_ctrl: NUM_LINKS*CODE_W must fill one byte");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("link_freq_ctrl: ADDR_W must cover the register addresses");
   end
   if (LCLK_W < 1 || LCLK_W > 2) begin : g_bad_lclk
      $error("link_freq_ctrl: LCLK_W must be 1 or 2");
   end

   logic                  wr_hit;
   logic [DATA_W-1:0]     field_bus;

   assign wr_hit = bus_wr_en && (bus_addr == ADDR_W'(FREQ_ADDR));

   for (genvar i = 0; i < NUM_LINKS; i++) begin : g_link
      freq_code_t cold_code;
      freq_code_t fld, tx, rx;
      logic       rsv;

      lfc_strap_decode #(
         .LCLK_W   (LCLK_W),
         .LCLK_200 (LCLK_200)
      ) i_strap (
         .core_sel  (strap_core_sel),
         .link_clk  (strap_link_clk[i*LCLK_W +: LCLK_W]),
         .alt_clk   (alt_clk_mode),
         .cold_code (cold_code)
      );

      lfc_link_field #(
         .RX_DEFAULT (RX_DEFAULT)
      ) i_field (
         .clk        (clk),
         .cold_rst_n (cold_rst_n),
         .warm_rst_n (warm_rst_n),
         .cold_code  (cold_code),
         .wr_hit     (wr_hit),
         .wr_code    (bus_wr_data[i*CODE_W +: CODE_W]),
         .sync_on    (sync_mode[i]),
         .field_q    (fld),
         .tx_sel     (tx),
         .rx_sel     (rx),
         .reserved   (rsv)
      );

      assign field_bus[i*CODE_W +: CODE_W]   = fld;
      assign tx_freq_sel[i*CODE_W +: CODE_W] = tx;
      assign rx_freq_sel[i*CODE_W +: CODE_W] = rx;
      assign code_reserved[i]                = rsv;
   end

   lfc_rd_mux #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .FREQ_ADDR (ADDR_W'(FREQ_ADDR)),
      .REV_ADDR  (ADDR_W'(REV_ADDR)),
      .REV_BYTE  (REV_BYTE)
   ) i_rd (
      .addr      (bus_addr),
      .freq_byte (field_bus),
      .rd_data   (bus_rd_data)
   );

endmodule

// File: rtl/link_freq_ctrl_chk.sv
module link_freq_ctrl_chk #(
   parameter int          NUM_LINKS  = 2,
   parameter int          ADDR_W     = 8,
   parameter logic [7:0]  FREQ_ADDR  = 8'h4D,
   parameter logic [7:0]  REV_ADDR   = 8'h4C,
   parameter logic [7:0]  REV_BYTE   = 8'h20,
   parameter logic [3:0]  RX_DEFAULT = 4'h0
) (
   input logic                   clk,
   input logic                   cold_rst_n,
   input logic                   warm_rst_n,
   input logic                   alt_clk_mode,
   input logic [NUM_LINKS-1:0]   sync_mode,
   input logic [ADDR_W-1:0]      bus_addr,
   input logic                   bus_wr_en,
   input logic [NUM_LINKS*4-1:0] bus_wr_data,
   input logic [NUM_LINKS*4-1:0] bus_rd_data,
   input logic [NUM_LINKS*4-1:0] tx_freq_sel,
   input logic [NUM_LINKS*4-1:0] rx_freq_sel,
   input logic [NUM_LINKS*4-1:0] field_bus
);

   assert_warm_hold_R4: assert property (@(posedge clk) disable iff (!cold_rst_n)
      !warm_rst_n |=> $stable(field_bus));

   assert_tx_frozen_R5: assert property (@(posedge clk) disable iff (!cold_rst_n)
      ($past(warm_rst_n) && $past(cold_rst_n)) |-> $stable(tx_freq_sel));

   assert_tx_release_R5: assert property (@(posedge clk) disable iff (!cold_rst_n)
      $rose(warm_rst_n) |-> (tx_freq_sel == field_bus));

   assert_write_store_R2: assert property (@(posedge clk) disable iff (!cold_rst_n)
      (bus_wr_en && warm_rst_n && bus_addr == ADDR_W'(FREQ_ADDR)) |=> (field_bus == $past(bus_wr_data)));

   assert_other_addr_R3: assert property (@(posedge clk) disable iff (!cold_rst_n)
      (bus_wr_en && warm_rst_n && bus_addr != ADDR_W'(FREQ_ADDR)) |=> $stable(field_bus));

   assert_rev_read_R8: assert property (@(posedge clk) disable iff (!cold_rst_n)
      (bus_addr == ADDR_W'(REV_ADDR)) |-> (bus_rd_data == REV_BYTE));

   for (genvar i = 0; i < NUM_LINKS; i++) begin : g_rx
      assert_rx_follow_R6: assert property (@(posedge clk) disable iff (!cold_rst_n)
         sync_mode[i] |-> (rx_freq_sel[i*4 +: 4] == tx_freq_sel[i*4 +: 4]));
      assert_rx_default_R6: assert property (@(posedge clk) disable iff (!cold_rst_n)
         !sync_mode[i] |-> (rx_freq_sel[i*4 +: 4] == RX_DEFAULT));
   end

   // cold reset with the alternate clock option forces the vendor code (R1, R9)
   logic seen_q = 1'b0;
   logic alt_cold_q = 1'b0;
   always_ff @(posedge clk) begin
      seen_q     <= 1'b1;
      alt_cold_q <= !cold_rst_n && alt_clk_mode;
      if (seen_q && alt_cold_q) begin
         assert_alt_cold_R1: assert (field_bus == '1 && tx_freq_sel == '1)
            else $error("alternate-clock cold reset did not load vendor codes");
      end
   end

endmodule

bind link_freq_ctrl link_freq_ctrl_chk #(
   .NUM_LINKS  (NUM_LINKS),
   .ADDR_W     (ADDR_W),
   .FREQ_ADDR  (FREQ_ADDR),
   .REV_ADDR   (REV_ADDR),
   .REV_BYTE   (REV_BYTE),
   .RX_DEFAULT (RX_DEFAULT)
) i_chk (
   .clk          (clk),
   .cold_rst_n   (cold_rst_n),
   .warm_rst_n   (warm_rst_n),
   .alt_clk_mode (alt_clk_mode),
   .sync_mode    (sync_mode),
   .bus_addr     (bus_addr),
   .bus_wr_en    (bus_wr_en),
   .bus_wr_data  (bus_wr_data),
   .bus_rd_data  (bus_rd_data),
   .tx_freq_sel  (tx_freq_sel),
   .rx_freq_sel  (rx_freq_sel),
   .field_bus    (field_bus)
);

// File: tb/test_link_freq_ctrl.sv
module test_link_freq_ctrl;

   logic       clk = 1'b0;
   logic       cold_rst_n, warm_rst_n, strap_core_sel, alt_clk_mode;
   logic [3:0] strap_link_clk;
   logic [1:0] sync_mode;
   logic [7:0] bus_addr, bus_wr_data, bus_rd_data, tx_freq_sel, rx_freq_sel;
   logic       bus_wr_en;
   logic [1:0] code_reserved;

   int n_tests = 0;
   int n_fail  = 0;
   bit run_cmp = 1'b0;
   bit ended   = 1'b0;

   logic [3:0] m_field [2];
   logic [3:0] m_active [2];

   always #10 clk = ~clk;

   link_freq_ctrl i_link_freq_ctrl (
      .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
      .strap_core_sel(strap_core_sel), .strap_link_clk(strap_link_clk),
      .alt_clk_mode(alt_clk_mode), .sync_mode(sync_mode),
      .bus_addr(bus_addr), .bus_wr_en(bus_wr_en), .bus_wr_data(bus_wr_data),
      .bus_rd_data(bus_rd_data), .tx_freq_sel(tx_freq_sel),
      .rx_freq_sel(rx_freq_sel), .code_reserved(code_reserved)
   );

   function automatic logic [3:0] cold_val(int link);
      logic [1:0] s;
      s = strap_link_clk[link*2 +: 2];
      if (alt_clk_mode) return 4'hF;
      if (strap_core_sel && s == 2'b01) return 4'h0;
      return 4'hF;
   endfunction

   function automatic logic is_rsv(logic [3:0] c);
      return !(c == 4'h0 || c == 4'h2 || c == 4'hF);
   endfunction

   // behavioural reference, advanced on every rising edge
   always @(posedge clk) begin
      if (!cold_rst_n) begin
         for (int i = 0; i < 2; i++) begin
            m_field[i]  = cold_val(i);
            m_active[i] = m_field[i];
         end
      end else if (!warm_rst_n) begin
         for (int i = 0; i < 2; i++) m_active[i] = m_field[i];
      end else if (bus_wr_en && bus_addr == 8'h4D) begin
         m_field[0] = bus_wr_data[3:0];
         m_field[1] = bus_wr_data[7:4];
      end
   end

   task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (run_cmp && !ended) begin
         logic [7:0] e_tx, e_rx, e_rd;
         logic [1:0] e_rsv;
         e_tx  = {m_active[1], m_active[0]};
         e_rx  = {sync_mode[1] ? m_active[1] : 4'h0, sync_mode[0] ? m_active[0] : 4'h0};
         e_rsv = {is_rsv(m_field[1]), is_rsv(m_field[0])};
         if (bus_addr == 8'h4D) begin
            e_rd = {m_field[1], m_field[0]};
            check("R2", "model rd", bus_rd_data, e_rd);
         end else if (bus_addr == 8'h4C) begin
            check("R8", "model rev", bus_rd_data, 8'h20);
         end else begin
            check("R3", "model undefined rd", bus_rd_data, 8'h00);
         end
         check("R5", "model tx", tx_freq_sel, e_tx);
         check("R6", "model rx", rx_freq_sel, e_rx);
         check("R7", "model reserved", {6'd0, code_reserved}, {6'd0, e_rsv});
      end
   end

   task automatic step(int n);
      repeat (n) begin
         @(posedge clk);
         #2;
      end
   endtask

   task automatic wr(logic [7:0] a, logic [7:0] d);
      bus_addr = a; bus_wr_data = d; bus_wr_en = 1'b1;
      step(1);
      bus_wr_en = 1'b0; bus_addr = 8'h4D;
   endtask

   task automatic warm_pulse();
      warm_rst_n = 1'b0; step(2); warm_rst_n = 1'b1;
   endtask

   task automatic cold_pulse();
      cold_rst_n = 1'b0; step(3); cold_rst_n = 1'b1;
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      step(100000);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      cold_rst_n = 1'b0; warm_rst_n = 1'b1; strap_core_sel = 1'b1;
      strap_link_clk = 4'b10_01; alt_clk_mode = 1'b0; sync_mode = 2'b00;
      bus_addr = 8'h4D; bus_wr_en = 1'b0; bus_wr_data = 8'h00;
      step(3);
      cold_rst_n = 1'b1;
      run_cmp = 1'b1;
      @(negedge clk);
      check("R1", "cold strap read", bus_rd_data, 8'hF0);
      check("R9", "cold tx", tx_freq_sel, 8'hF0);
      step(1);

      wr(8'h4D, 8'h02);
      @(negedge clk);
      check("R2", "readback", bus_rd_data, 8'h02);
      check("R5", "tx pending", tx_freq_sel, 8'hF0);

      wr(8'h4C, 8'hFF);
      bus_addr = 8'h4C;
      @(negedge clk);
      check("R8", "rev after write", bus_rd_data, 8'h20);
      bus_addr = 8'h50; step(1);
      wr(8'h50, 8'h99);
      bus_addr = 8'h50;
      @(negedge clk);
      check("R3", "undefined read", bus_rd_data, 8'h00);
      bus_addr = 8'h4D; step(1);
      @(negedge clk);
      check("R3", "field untouched", bus_rd_data, 8'h02);

      warm_rst_n = 1'b0; step(1);
      bus_wr_en = 1'b1; bus_wr_data = 8'h55; step(2);
      bus_wr_en = 1'b0; warm_rst_n = 1'b1;
      @(negedge clk);
      check("R4", "write in warm reset", bus_rd_data, 8'h02);
      check("R5", "tx after warm", tx_freq_sel, 8'h02);

      sync_mode = 2'b01; @(negedge clk);
      check("R6", "rx sync link0", rx_freq_sel, 8'h02);
      sync_mode = 2'b10; @(negedge clk);
      check("R6", "rx sync link1", rx_freq_sel, 8'h00);
      step(1);

      wr(8'h4D, 8'h37);
      @(negedge clk);
      check("R7", "both reserved", {6'd0, code_reserved}, 8'h03);
      check("R5", "tx held", tx_freq_sel, 8'h02);
      warm_pulse();
      @(negedge clk);
      check("R5", "tx new", tx_freq_sel, 8'h37);
      check("R6", "rx link1", rx_freq_sel, 8'h30);
      sync_mode = 2'b01; @(negedge clk);
      check("R6", "rx link0", rx_freq_sel, 8'h07);
      sync_mode = 2'b11; step(1);

      wr(8'h4D, 8'h3F);
      @(negedge clk);
      check("R7", "link1 reserved", {6'd0, code_reserved}, 8'h02);
      wr(8'h4D, 8'h20);
      @(negedge clk);
      check("R7", "none reserved", {6'd0, code_reserved}, 8'h00);

      alt_clk_mode = 1'b1; strap_link_clk = 4'b01_01; cold_pulse();
      @(negedge clk);
      check("R1", "alt clock cold", bus_rd_data, 8'hFF);
      check("R9", "alt clock tx", tx_freq_sel, 8'hFF);
      alt_clk_mode = 1'b0; strap_core_sel = 1'b0; cold_pulse();
      @(negedge clk);
      check("R1", "core strap off", bus_rd_data, 8'hFF);
      strap_core_sel = 1'b1; cold_pulse();
      @(negedge clk);
      check("R1", "both recognised", bus_rd_data, 8'h00);
      check("R9", "tx recognised", tx_freq_sel, 8'h00);

      strap_core_sel = 1'b0; warm_pulse();
      @(negedge clk);
      check("R4", "warm keeps field", bus_rd_data, 8'h00);
      check("R4", "warm keeps tx", tx_freq_sel, 8'h00);
      step(2);
      finish_run();
   end

endmodule